// File: doc/BRIEF.md
# Residue to Mixed-Radix Converter with Sign Output

This block turns a number held in residue form over the three moduli 64, 63 and 31 into mixed-radix digits, one conversion accepted per clock. The represented integer is X = a1 + 64·a2 + 4032·a3, where a1 is the mod-64 residue itself. The range is 0 to 124991. The block computes the middle digit a2 (radix 63) and the top digit a3 (radix 31) with modular subtractors and constant multiplications by modular inverses. With this moduli set those inverses reduce to the fixed values 1 and 16.

The flow is a three-stage pipeline. The first stage registers the incoming residues after reducing each one into the range of the modulus it is compared against. The second stage forms a2 and the scaled mod-31 difference. The third stage forms a3 and registers both output digits. The sign of a number read as signed is taken from bit 4 of the top digit, so it is negative when that digit is 16 or more. A valid flag follows the data through the pipeline and marks when the outputs hold converted values after reset.

Top module: `rns_mixed_radix`

## Requirements
- R1: A synchronous active-high reset clears mrMid, mrHigh, signNeg and validOut at the next rising edge. They stay cleared while reset is held.
- R2: After reset is released, validOut is 0 following the first and second rising edges and becomes 1 at the third. It then stays 1 until the next reset.
- R3: mrMid equals (resB − resA) mod 63, with each operand first reduced mod 63.
- R4: mrHigh equals (16·(resC − resA) − mrMid) mod 31, with every operand first reduced mod 31. It always lies in 0..30, so bit 5 is 0.
- R5: signNeg is 1 exactly when mrHigh is 16 or more, that is when bit 4 of mrHigh is set.
- R6: Inputs sampled at rising edge E produce outputs that appear after edge E+2. A new conversion is accepted every cycle, with no gaps between them.
- R7: Residue codes outside their modulus are treated as their value mod that modulus. This covers resB = 63 and resC from 31 to 63.
- R8: For every X in 0..124991 driven as (X mod 64, X mod 63, X mod 31), resA + 64·mrMid + 4032·mrHigh equals X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| resA | input | 6 | Residue modulo 64 (also the least significant mixed-radix digit) |
| resB | input | 6 | Residue modulo 63 |
| resC | input | 6 | Residue modulo 31 |
| mrMid | output | 6 | Middle mixed-radix digit, radix 63 |
| mrHigh | output | 6 | Top mixed-radix digit, radix 31 |
| signNeg | output | 1 | 1 when the represented number is negative |
| validOut | output | 1 | Outputs hold a converted value |

## Verification
All three outputs come from the same third register stage. Digits and sign driven on one falling edge are therefore due on the third falling edge after it. The bench streams one vector per cycle. At each falling edge it compares the outputs against the vector driven three falling edges earlier, and only then drives the next vector. Reset and refill checks count edges in the same way: outputs are cleared one edge after reset is applied, and validOut is due three edges after release.

// File: rtl/rmr_pkg.sv
package rmr_pkg;
  localparam int DIGIT_W = 6;

  typedef struct packed {
    logic adv1;
    logic adv2;
    logic adv3;
  } rmrStrobe_t;
endpackage

// File: rtl/rmr_modsub.sv
// (a - b) mod M for operands already in 0..M-1
module rmr_modsub #(
  parameter int W = 6,
  parameter int M = 63
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W:0] MOD = (W+1)'(M);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, a} + MOD - {1'b0, b};
    y = (sum >= MOD) ? W'(sum - MOD) : W'(sum);
  end
endmodule

// File: rtl/rmr_mulconst.sv
// (K * a) mod M for an operand already in 0..M-1
module rmr_mulconst #(
  parameter int W = 6,
  parameter int M = 31,
  parameter int K = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  generate
    if (K == 1) begin : g_unit
      assign y = a;
    end else begin : g_scale
      localparam int PW = W + $clog2(K + 1);
      logic [PW-1:0] prod;
      assign prod = PW'(a) * PW'(K);
      assign y = W'(prod % PW'(M));
    end
  endgenerate
endmodule

// File: rtl/rmr_ctrl.sv
module rmr_ctrl
  import rmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output rmrStrobe_t stb,
  output logic       validOut
);
  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= 1'b1;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    stb.adv1 = ~rst;
    stb.adv2 = v1;
    stb.adv3 = v2;
  end
  assign validOut = v3;

  // R2: once valid, stays valid until reset
  p_valid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    validOut |=> validOut);
  // R6: the stages fill in order
  p_fill_order_r6: assert property (@(posedge clk) disable iff (rst)
    stb.adv3 |-> stb.adv2);
  // R2: valid never appears on the first edge after reset
  p_valid_late_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !validOut);
endmodule

// File: rtl/rmr_datapath.sv
module rmr_datapath
  import rmr_pkg::*;
#(
  parameter int DW    = 6,
  parameter int M1    = 64,
  parameter int M2    = 63,
  parameter int M3    = 31,
  parameter int INV12 = 1,
  parameter int INV13 = 16,
  parameter int INV23 = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  rmrStrobe_t    stb,
  input  logic [DW-1:0] resA,
  input  logic [DW-1:0] resB,
  input  logic [DW-1:0] resC,
  output logic [DW-1:0] mrMid,
  output logic [DW-1:0] mrHigh,
  output logic          signNeg
);
  localparam int SIGN_BIT = $clog2(M3) - 1;

  // stage 1: operand reduction
  logic [DW-1:0] lowDigit;
  logic [DW-1:0] s1LowM2, s1ResB, s1LowM3, s1ResC;
  assign lowDigit = DW'(resA % M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1LowM2 <= '0;
      s1ResB  <= '0;
      s1LowM3 <= '0;
      s1ResC  <= '0;
    end else if (stb.adv1) begin
      s1LowM2 <= DW'(lowDigit % M2);
      s1ResB  <= DW'(resB % M2);
      s1LowM3 <= DW'(lowDigit % M3);
      s1ResC  <= DW'(resC % M3);
    end
  end

  // stage 2: middle digit and scaled mod-M3 difference
  logic [DW-1:0] diffM2, midNext, diffM3, scaledM3;
  logic [DW-1:0] s2Mid, s2Scaled;

  rmr_modsub #(.W(DW), .M(M2)) u_subMid (.a(s1ResB), .b(s1LowM2), .y(diffM2));
  rmr_mulconst #(.W(DW), .M(M2), .K(INV12)) u_mulMid (.a(diffM2), .y(midNext));
  rmr_modsub #(.W(DW), .M(M3)) u_subTop (.a(s1ResC), .b(s1LowM3), .y(diffM3));
  rmr_mulconst #(.W(DW), .M(M3), .K(INV13)) u_mulTop (.a(diffM3), .y(scaledM3));

  always_ff @(posedge clk) begin
    if (rst) begin
      s2Mid    <= '0;
      s2Scaled <= '0;
    end else if (stb.adv2) begin
      s2Mid    <= midNext;
      s2Scaled <= scaledM3;
    end
  end

  // stage 3: top digit and sign
  logic [DW-1:0] midRed, midScaled, highNext;
  assign midRed = DW'(s2Mid % M3);

  rmr_mulconst #(.W(DW), .M(M3), .K(INV23)) u_mulMix (.a(midRed), .y(midScaled));
  rmr_modsub #(.W(DW), .M(M3)) u_subFin (.a(s2Scaled), .b(midScaled), .y(highNext));

  always_ff @(posedge clk) begin
    if (rst) begin
      mrMid   <= '0;
      mrHigh  <= '0;
      signNeg <= 1'b0;
    end else if (stb.adv3) begin
      mrMid   <= s2Mid;
      mrHigh  <= highNext;
      signNeg <= highNext[SIGN_BIT];
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mrMid == '0 && mrHigh == '0 && !signNeg));
  p_mid_range_r3: assert property (@(posedge clk) disable iff (rst)
    mrMid < DW'(M2));
  p_high_range_r4: assert property (@(posedge clk) disable iff (rst)
    mrHigh < DW'(M3));
  p_sign_set_r5: assert property (@(posedge clk) disable iff (rst)
    signNeg |-> mrHigh >= DW'(1 << SIGN_BIT));
  p_sign_clr_r5: assert property (@(posedge clk) disable iff (rst)
    !signNeg |-> mrHigh < DW'(1 << SIGN_BIT));
endmodule

// File: rtl/rns_mixed_radix.sv
module rns_mixed_radix
  import rmr_pkg::*;
#(
  parameter int M1    = 64,
  parameter int M2    = 63,
  parameter int M3    = 31,
  parameter int INV12 = 1,
  parameter int INV13 = 16,
  parameter int INV23 = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] resA,
  input  logic [DIGIT_W-1:0] resB,
  input  logic [DIGIT_W-1:0] resC,
  output logic [DIGIT_W-1:0] mrMid,
  output logic [DIGIT_W-1:0] mrHigh,
  output logic               signNeg,
  output logic               validOut
);
  rmrStrobe_t stb;

  rmr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .stb(stb), .validOut(validOut)
  );

  rmr_datapath #(
    .DW(DIGIT_W), .M1(M1), .M2(M2), .M3(M3),
    .INV12(INV12), .INV13(INV13), .INV23(INV23)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .resA(resA), .resB(resB), .resC(resC),
    .mrMid(mrMid), .mrHigh(mrHigh), .signNeg(signNeg)
  );
endmodule

// File: tb/sim_rns_mixed_radix.sv
module sim_rns_mixed_radix;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] resA = '0, resB = '0, resC = '0;
  logic [5:0] mrMid, mrHigh;
  logic signNeg, validOut;

  int tests = 0;
  int fails = 0;

  localparam int NVEC = 16;
  localparam int VEC_X [NVEC] = '{0, 1, 63, 64, 4031, 4032, 60479, 64511,
                                  64512, 124991, 2016, 12345, 77777, 100000,
                                  120959, 4095};

  int stimX [128];
  logic [5:0] stimA [128], stimB [128], stimC [128];

  always #10 clk = ~clk;

  rns_mixed_radix u0 (
    .clk(clk), .rst(rst), .resA(resA), .resB(resB), .resC(resC),
    .mrMid(mrMid), .mrHigh(mrHigh), .signNeg(signNeg), .validOut(validOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setVec(input int i, input int x, input bit wideCodes);
    stimX[i] = x;
    stimA[i] = 6'(x % 64);
    stimB[i] = 6'(x % 63);
    stimC[i] = 6'(x % 31);
    if (wideCodes) begin
      stimC[i] = 6'(x % 31 + 31);
      if (x % 63 == 0) stimB[i] = 6'd63;
    end
  endtask

  task automatic checkVec(input int i, input string tagOut);
    int x, eMid, eHigh, back;
    x = stimX[i];
    eMid = (x / 64) % 63;
    eHigh = x / 4032;
    back = int'(stimA[i]) + 64 * int'(mrMid) + 4032 * int'(mrHigh);
    check(int'(mrMid) == eMid, {tagOut, " mid R3"}, int'(mrMid), eMid);
    check(int'(mrHigh) == eHigh, {tagOut, " high R4"}, int'(mrHigh), eHigh);
    check(signNeg == (eHigh >= 16), {tagOut, " sign R5"}, int'(signNeg), int'(eHigh >= 16));
    check(back == x, {tagOut, " roundtrip R8"}, back, x);
    check(validOut == 1'b1, {tagOut, " valid R6"}, int'(validOut), 1);
  endtask

  task automatic runStream(input int n, input string tagOut);
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk);
      if (i >= 3) checkVec(i - 3, tagOut);
      if (i < n) begin
        resA = stimA[i]; resB = stimB[i]; resC = stimC[i];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    resA = 6'd5; resB = 6'd9; resC = 6'd20;
    repeat (3) @(negedge clk);
    // R1: cleared while reset held
    check(mrMid == 0 && mrHigh == 0, "R1 digits in reset", int'(mrHigh), 0);
    check(!signNeg && !validOut, "R1 flags in reset", int'(signNeg) + int'(validOut), 0);

    // R2: valid timing after release
    rst = 1'b0;
    @(negedge clk);
    check(!validOut, "R2 valid after edge 1", int'(validOut), 0);
    @(negedge clk);
    check(!validOut, "R2 valid after edge 2", int'(validOut), 0);
    @(negedge clk);
    check(validOut, "R2 valid after edge 3", int'(validOut), 1);

    // table of corner values, back to back (R6)
    for (int i = 0; i < NVEC; i++) setVec(i, VEC_X[i], 1'b0);
    runStream(NVEC, "table");

    // sweep across the range, R8
    for (int i = 0; i < 100; i++) setVec(i, (i * 1249 + 17) % 124992, 1'b0);
    runStream(100, "sweep");

    // R7: out-of-range codes reduce
    setVec(0, 0, 1'b1);
    setVec(1, 4032, 1'b1);
    setVec(2, 64512, 1'b1);
    setVec(3, 124991, 1'b1);
    setVec(4, 30, 1'b1);
    setVec(5, 99999, 1'b1);
    runStream(6, "R7 wide");

    // R1: reset mid-stream clears at next edge
    @(negedge clk);
    resA = 6'd7; resB = 6'd40; resC = 6'd25;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(mrMid == 0 && mrHigh == 0 && !signNeg, "R1 mid-stream clear", int'(mrMid), 0);
    check(!validOut, "R1 mid-stream valid", int'(validOut), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!validOut, "R2 refill early", int'(validOut), 0);
    setVec(0, 64512 + 63, 1'b0);
    setVec(1, 64511, 1'b0);
    runStream(2, "refill");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule